// File: doc/BRIEF.md
# Leaf Page Permission Checker

This block decides whether a leaf page-table entry lets an access through. It takes the kind of access (instruction fetch, data load or data store), the current privilege level, a handful of status controls and the flag bits of the leaf entry. From these it derives the privilege the access really runs at, says whether address translation is skipped for it, and produces a registered allow/fault verdict one cycle after a check is requested.

The effective privilege is combinational. The data-side privilege override can substitute the saved previous privilege for loads and stores, but not while a debug cause is active. A bare translation mode forces machine level, and machine level skips translation. The verdict is registered. It comes from an ordered chain of checks: first page ownership (user pages against supervisor code under user-memory protection, and supervisor-only pages against everyone else), then the reserved write-without-read encoding, then the per-access-type rights, in which loads can be allowed to read execute-only pages. The table walker calls this block once it holds a leaf entry. When bypass is high, the walker ignores the verdict.

Top module: `pte_perm_check`

## Requirements
- R1: Privilege codes are user=0, supervisor=1, machine=3. Access codes are fetch=0, load=1, store=2. For a fetch (acc_type=0), eff_priv equals cur_priv unless R3 applies.
- R2: For any non-fetch access, eff_priv equals prev_priv when mprv_en=1 and dbg_active=0. Otherwise it equals cur_priv, unless R3 applies.
- R3: When xlate_mode equals BARE_CODE (default 0), eff_priv is 3, whatever the access type and overrides.
- R4: bypass is 1 exactly when eff_priv is 3.
- R5: pte_flags fields are read at bit 1, write at bit 2, execute at bit 3 and user at bit 4. Bit 0 and bits above 4 are not examined. An entry with the user bit set faults when eff_priv is 1 and user_prot is 1.
- R6: An entry with the user bit clear faults whenever eff_priv is not 1.
- R7: An entry with read=0 and write=1 always faults.
- R8: A fetch is allowed only if the execute bit is set.
- R9: A load is allowed only if the read bit is set, or if the execute bit is set while exec_readable=1.
- R10: A store, and the unused access code 3, is allowed only if both the read and write bits are set.
- R11: An access that passes R5 to R10 is allowed. The verdict for the inputs present at a clock edge with chk_valid=1 appears on res_allow (1=allow, 0=fault) after that edge, with res_valid=1 for exactly the cycles that follow a chk_valid=1 edge.
- R12: After reset, res_valid and res_allow are 0. At edges with chk_valid=0, res_allow keeps its value and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | Request a verdict for the present inputs |
| acc_type | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| cur_priv | input | 2 | Current privilege level |
| mprv_en | input | 1 | Data accesses use prev_priv |
| prev_priv | input | 2 | Saved previous privilege |
| user_prot | input | 1 | Supervisor may not touch user pages |
| exec_readable | input | 1 | Loads may read execute-only pages |
| xlate_mode | input | MODE_W | Translation mode code |
| dbg_active | input | 1 | Debug cause active; blocks the data override |
| pte_flags | input | FLAG_W | Leaf entry flag bits |
| eff_priv | output | 2 | Effective privilege (combinational) |
| bypass | output | 1 | Translation skipped (combinational) |
| res_valid | output | 1 | Verdict strobe |
| res_allow | output | 1 | Registered verdict, 1 = allow |

## Verification
The bench builds the block with its default parameters: a 4-bit translation mode with bare at code 0, and an 8-bit flag vector. With a 4-bit mode, random stimulus lands on both bare and non-bare codes. The 8-bit flags leave don't-care bits (the valid bit and the upper bits) that the random stimulus toggles, so an accidental dependence on them shows up in the results. Random draws cover all four access codes, including the unused one, together with every privilege code, including the reserved value 2. Directed cases hit the debug-blocked override, the write-without-read encoding and the verdict holding while idle.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;
   typedef logic [1:0] priv_t;
   typedef logic [1:0] acc_t;

   localparam priv_t PRIV_USER  = 2'd0;
   localparam priv_t PRIV_SUPER = 2'd1;
   localparam priv_t PRIV_MACH  = 2'd3;

   localparam acc_t ACC_FETCH = 2'd0;
   localparam acc_t ACC_LOAD  = 2'd1;
   localparam acc_t ACC_STORE = 2'd2;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
      logic usr;
   } leaf_flags_t;
endpackage

// File: rtl/eff_priv_sel.sv
module eff_priv_sel
   import pte_chk_pkg::*;
#(
   parameter int MODE_W    = 4,
   parameter int BARE_CODE = 0
) (
   input  acc_t              acc_type,
   input  priv_t             cur_priv,
   input  logic              mprv_en,
   input  priv_t             prev_priv,
   input  logic              dbg_active,
   input  logic [MODE_W-1:0] xlate_mode,
   output priv_t             eff_priv,
   output logic              bypass
);
   localparam logic [MODE_W-1:0] BARE_V = MODE_W'(BARE_CODE);

   if (MODE_W < 1) begin : g_bad_mode_w
      $error("MODE_W must be at least 1");
   end
   if (BARE_CODE < 0 || BARE_CODE >= (1 << MODE_W)) begin : g_bad_bare
      $error("BARE_CODE does not fit in MODE_W bits");
   end

   logic  data_side;
   logic  is_bare;
   priv_t pick;

   always_comb begin
      data_side = (acc_type != ACC_FETCH);
      is_bare   = (xlate_mode == BARE_V);
      pick      = cur_priv;
      if (data_side && mprv_en && !dbg_active)
         pick = prev_priv;
      if (is_bare)
         pick = PRIV_MACH;
      eff_priv = pick;
      bypass   = (pick == PRIV_MACH);
   end
endmodule

// File: rtl/flag_unpack.sv
module flag_unpack
   import pte_chk_pkg::*;
#(
   parameter int FLAG_W  = 8,
   parameter int RD_POS  = 1,
   parameter int WR_POS  = 2,
   parameter int EX_POS  = 3,
   parameter int USR_POS = 4
) (
   input  logic [FLAG_W-1:0] flags_in,
   output leaf_flags_t       flags_out
);
   localparam int MAX_POS = (RD_POS > WR_POS ? RD_POS : WR_POS) > (EX_POS > USR_POS ? EX_POS : USR_POS)
                          ? (RD_POS > WR_POS ? RD_POS : WR_POS) : (EX_POS > USR_POS ? EX_POS : USR_POS);

   if (MAX_POS >= FLAG_W) begin : g_bad_width
      $error("flag position beyond FLAG_W");
   end
   if (RD_POS == WR_POS || RD_POS == EX_POS || RD_POS == USR_POS ||
       WR_POS == EX_POS || WR_POS == USR_POS || EX_POS == USR_POS) begin : g_bad_overlap
      $error("flag positions must be distinct");
   end

   assign flags_out.rd  = flags_in[RD_POS];
   assign flags_out.wr  = flags_in[WR_POS];
   assign flags_out.ex  = flags_in[EX_POS];
   assign flags_out.usr = flags_in[USR_POS];
endmodule

// File: rtl/leaf_perm_eval.sv
module leaf_perm_eval
   import pte_chk_pkg::*;
(
   input  acc_t        acc_type,
   input  priv_t       eff_priv,
   input  logic        user_prot,
   input  logic        exec_readable,
   input  leaf_flags_t flags,
   output logic        allow
);
   logic is_super;

   always_comb begin
      is_super = (eff_priv == PRIV_SUPER);
      if (flags.usr ? (is_super && user_prot) : !is_super)
         allow = 1'b0;                               // ownership check first
      else if (!flags.rd && flags.wr)
         allow = 1'b0;                               // reserved encoding
      else begin
         case (acc_type)
            ACC_FETCH: allow = flags.ex;
            ACC_LOAD:  allow = flags.rd || (exec_readable && flags.ex);
            default:   allow = flags.rd && flags.wr;
         endcase
      end
   end
endmodule

// File: rtl/result_stage.sv
module result_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic chk_valid,
   input  logic allow_in,
   output logic res_valid,
   output logic res_allow
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_allow <= 1'b0;
      end else begin
         res_valid <= chk_valid;
         if (chk_valid)
            res_allow <= allow_in;
      end
   end
endmodule

// File: rtl/pte_perm_check.sv
module pte_perm_check
   import pte_chk_pkg::*;
#(
   parameter int MODE_W    = 4,
   parameter int BARE_CODE = 0,
   parameter int FLAG_W    = 8,
   parameter int RD_POS    = 1,
   parameter int WR_POS    = 2,
   parameter int EX_POS    = 3,
   parameter int USR_POS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_valid,
   input  logic [1:0]        acc_type,
   input  logic [1:0]        cur_priv,
   input  logic              mprv_en,
   input  logic [1:0]        prev_priv,
   input  logic              user_prot,
   input  logic              exec_readable,
   input  logic [MODE_W-1:0] xlate_mode,
   input  logic              dbg_active,
   input  logic [FLAG_W-1:0] pte_flags,
   output logic [1:0]        eff_priv,
   output logic              bypass,
   output logic              res_valid,
   output logic              res_allow
);
   leaf_flags_t fl;
   logic        allow_c;

   eff_priv_sel #(.MODE_W(MODE_W), .BARE_CODE(BARE_CODE)) u_priv (
      .acc_type(acc_type), .cur_priv(cur_priv), .mprv_en(mprv_en),
      .prev_priv(prev_priv), .dbg_active(dbg_active), .xlate_mode(xlate_mode),
      .eff_priv(eff_priv), .bypass(bypass)
   );

   flag_unpack #(.FLAG_W(FLAG_W), .RD_POS(RD_POS), .WR_POS(WR_POS),
                 .EX_POS(EX_POS), .USR_POS(USR_POS)) u_flags (
      .flags_in(pte_flags), .flags_out(fl)
   );

   leaf_perm_eval u_eval (
      .acc_type(acc_type), .eff_priv(eff_priv), .user_prot(user_prot),
      .exec_readable(exec_readable), .flags(fl), .allow(allow_c)
   );

   result_stage u_res (
      .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .allow_in(allow_c),
      .res_valid(res_valid), .res_allow(res_allow)
   );

   localparam logic [MODE_W-1:0] BARE_V = MODE_W'(BARE_CODE);

   assert_fetch_cur_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_type == ACC_FETCH && xlate_mode != BARE_V) |-> eff_priv == cur_priv);

   assert_bare_mach_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xlate_mode == BARE_V) |-> (eff_priv == PRIV_MACH && bypass));

   assert_user_prot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && pte_flags[USR_POS] && eff_priv == PRIV_SUPER && user_prot) |=> !res_allow);

   assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && !pte_flags[RD_POS] && pte_flags[WR_POS]) |=> !res_allow);

   assert_load_rights_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && acc_type == ACC_LOAD && !pte_flags[RD_POS] &&
       !(exec_readable && pte_flags[EX_POS])) |=> !res_allow);

   assert_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> res_valid);

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> (!res_valid && $stable(res_allow)));
endmodule

// File: tb/test_pte_perm_check.sv
`timescale 1ns/1ps
module test_pte_perm_check;
   localparam int MODE_W = 4;
   localparam int FLAG_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chk_valid = 1'b0;
   logic [1:0] acc_type = '0, cur_priv = '0, prev_priv = '0;
   logic mprv_en = 1'b0, user_prot = 1'b0, exec_readable = 1'b0, dbg_active = 1'b0;
   logic [MODE_W-1:0] xlate_mode = '0;
   logic [FLAG_W-1:0] pte_flags = '0;
   logic [1:0] eff_priv;
   logic bypass, res_valid, res_allow;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pte_perm_check i_pte_perm_check (
      .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .acc_type(acc_type),
      .cur_priv(cur_priv), .mprv_en(mprv_en), .prev_priv(prev_priv),
      .user_prot(user_prot), .exec_readable(exec_readable), .xlate_mode(xlate_mode),
      .dbg_active(dbg_active), .pte_flags(pte_flags), .eff_priv(eff_priv),
      .bypass(bypass), .res_valid(res_valid), .res_allow(res_allow)
   );

   function automatic logic [1:0] ref_eff();
      logic [1:0] p;
      p = cur_priv;
      if (acc_type != 2'd0 && mprv_en && !dbg_active) p = prev_priv;
      if (xlate_mode == '0) p = 2'd3;
      return p;
   endfunction

   function automatic logic ref_allow(logic [1:0] ep);
      logic r, w, x, u, s;
      r = pte_flags[1]; w = pte_flags[2]; x = pte_flags[3]; u = pte_flags[4];
      s = (ep == 2'd1);
      if (u && s && user_prot) return 1'b0;
      if (!u && !s) return 1'b0;
      if (!r && w) return 1'b0;
      if (acc_type == 2'd0) return x;
      if (acc_type == 2'd1) return r || (exec_readable && x);
      return r && w;
   endfunction

   task automatic check1(string req, logic [1:0] act, logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive at negedge, check comb outputs, then check the verdict at the next negedge.
   task automatic run_one(string req);
      logic [1:0] e_p;
      logic e_a;
      #1;
      e_p = ref_eff();
      e_a = ref_allow(e_p);
      check1({req, "/R1R2R3 eff_priv"}, eff_priv, e_p);
      check1("R4 bypass", {1'b0, bypass}, {1'b0, e_p == 2'd3});
      @(negedge clk);
      check1("R11 res_valid", {1'b0, res_valid}, 2'd1);
      check1({req, "/R11 res_allow"}, {1'b0, res_allow}, {1'b0, e_a});
   endtask

   task automatic set_in(logic [1:0] at, logic [1:0] cp, logic mp, logic [1:0] pp,
                         logic up, logic xr, logic [MODE_W-1:0] md, logic dbg,
                         logic [FLAG_W-1:0] fl);
      acc_type = at; cur_priv = cp; mprv_en = mp; prev_priv = pp; user_prot = up;
      exec_readable = xr; xlate_mode = md; dbg_active = dbg; pte_flags = fl;
      chk_valid = 1'b1;
   endtask

   initial begin
      logic held;
      void'($urandom(32'd12345));
      #35;
      check1("R12 reset res_valid", {1'b0, res_valid}, 2'd0);
      check1("R12 reset res_allow", {1'b0, res_allow}, 2'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // flags: R=bit1 W=bit2 X=bit3 U=bit4
      set_in(2'd1, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd8, 1'b0, 8'h03); run_one("R2 mprv load");
      set_in(2'd1, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd8, 1'b1, 8'h13); run_one("R2 dbg blocks");
      set_in(2'd0, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd8, 1'b0, 8'h19); run_one("R1 fetch cur");
      set_in(2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0, 1'b0, 8'h07); run_one("R3 bare");
      set_in(2'd1, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 4'd8, 1'b0, 8'h13); run_one("R5 user prot");
      set_in(2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8, 1'b0, 8'h13); run_one("R5 prot off");
      set_in(2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8, 1'b0, 8'h03); run_one("R6 user on sup page");
      set_in(2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8, 1'b0, 8'h0D); run_one("R7 reserved");
      set_in(2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8, 1'b0, 8'h03); run_one("R8 no exec");
      set_in(2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 4'd8, 1'b0, 8'h09); run_one("R9 exec readable");
      set_in(2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8, 1'b0, 8'h09); run_one("R9 exec only");
      set_in(2'd3, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8, 1'b0, 8'h03); run_one("R10 code3 no w");
      set_in(2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 4'd8, 1'b0, 8'h07); run_one("R10 store rw");

      // R12 hold: verdict is 1 now; idle with faulting inputs
      held = res_allow;
      chk_valid = 1'b0; pte_flags = 8'h04; cur_priv = 2'd0;
      @(negedge clk);
      check1("R12 idle res_valid", {1'b0, res_valid}, 2'd0);
      check1("R12 idle hold", {1'b0, res_allow}, {1'b0, held});

      for (int i = 0; i < 3000; i++) begin
         set_in(2'($urandom), 2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                1'($urandom), (($urandom % 4) == 0) ? 4'd0 : 4'($urandom),
                1'($urandom), 8'($urandom));
         run_one("R5-R10 random");
      end

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule